// File: doc/BRIEF.md
# Bucketed receive message FIFO

This block is the receive side of one station on a message ring. It owns a single 256-entry message store. At run time, software divides that store into as many as eight buckets, and each bucket behaves as an independent circular queue. A message arriving from the ring carries a bucket number and a sender ID, and it is appended to that bucket. A consumer pops from any bucket it chooses. Each successful pop delivers the stored message, and in the same cycle it returns one credit to the sender that wrote the message, tagged with that bucket.

A bucket's region starts at the sum of the sizes of all lower-numbered buckets. Its size must be zero or a power of two, and its start offset must be a multiple of its size. A layout that breaks these rules, or that uses more than 256 entries in total, raises a sticky configuration error. A bucket of size zero accepts nothing.

Top module: `msgq_rx_station`

## Requirements
- R1: After reset every bucket has size 0, `not_empty_o` and `overflow_o` are all zero, `cfg_error_o` is 0, and neither `rd_valid_o` nor `crd_valid_o` is asserted.
- R2: Messages written to one bucket come out of that bucket in arrival order. A pop accepted at a clock edge presents `rd_data_o` and `rd_src_o` with `rd_valid_o` high in the cycle after that edge.
- R3: A write to a bucket that is full, or whose size is 0, is dropped. It sets that bucket's bit in `overflow_o` one cycle later, and the bit stays set until reset.
- R4: Every accepted pop asserts `crd_valid_o` for exactly one cycle, in the same cycle as `rd_valid_o`. `crd_bkt_o` carries the popped bucket number and `crd_src_o` carries the sender ID stored with that message.
- R5: A pop of an empty bucket is ignored. It produces no `rd_valid_o` and no credit.
- R6: Bit b of `not_empty_o` is 1 exactly when bucket b holds at least one message. It reflects each write or pop in the cycle after the edge that accepted it.
- R7: Bucket b occupies the entries starting at the sum of the sizes of buckets 0..b-1. Filling one bucket to capacity does not disturb the contents of the bucket next to it.
- R8: `cfg_error_o` goes high on the second edge after a configuration write that leaves the layout in one of these states: some non-zero size is not a power of two, some bucket starts at an offset that is not a multiple of its size, or the sizes add up to more than 256. It then stays high until reset. A legal layout leaves it low.
- R9: A configuration write to a bucket sets that bucket's size and discards everything the bucket holds.
- R10: A bucket's read and write positions wrap within its own region, so it can pass any number of messages, more than its size, in FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Bucket size write strobe |
| cfg_bkt_i | input | 3 | Bucket being configured |
| cfg_size_i | input | 9 | New bucket size (0 or a power of two, at most 256) |
| wr_valid_i | input | 1 | Incoming message strobe |
| wr_bkt_i | input | 3 | Destination bucket of the incoming message |
| wr_src_i | input | 4 | Sender ID of the incoming message |
| wr_data_i | input | 32 | Message payload |
| rd_pop_i | input | 1 | Pop request |
| rd_bkt_i | input | 3 | Bucket to pop |
| rd_valid_o | output | 1 | Popped message is valid |
| rd_data_o | output | 32 | Popped payload |
| rd_src_o | output | 4 | Sender ID of the popped message |
| not_empty_o | output | 8 | Per-bucket non-empty flags |
| crd_valid_o | output | 1 | Credit return strobe |
| crd_bkt_o | output | 3 | Bucket the credit belongs to |
| crd_src_o | output | 4 | Sender that receives the credit |
| overflow_o | output | 8 | Per-bucket sticky dropped-write flags |
| cfg_error_o | output | 1 | Sticky illegal-layout flag |

## Verification
The hardest situation to reach is a bucket whose pointers wrap while its neighbour is full. The write position and the read position must both cross the region boundary while the adjacent entries belong to another queue. The bench therefore configures the tightest legal layout, with sizes 4, 4, 8, 16, 32, 64 and 128, which fills all 256 entries. It fills the two smallest buckets back to back and pushes one extra message to force an overflow. It then drains one bucket and cycles it through several partial fill-and-drain rounds, so that its pointers wrap repeatedly next to the full bucket. Each of the three kinds of illegal layout is applied after a fresh reset, because the error flag is sticky.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  function automatic logic is_pow2_or_zero(input logic [31:0] v);
    return (v & (v - 32'd1)) == 32'd0;
  endfunction
endpackage

// File: rtl/msgq_layout.sv
module msgq_layout
  import msgq_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int NUM_BKT = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int SW     = AW + 1,
  localparam int BW     = $clog2(NUM_BKT),
  localparam int ACCW   = SW + BW
) (
  input  logic [SW-1:0] size_i [NUM_BKT],
  output logic [AW-1:0] base_o [NUM_BKT],
  output logic          bad_o
);
  logic [ACCW-1:0] acc;
  logic [ACCW-1:0] sz;

  always_comb begin
    acc   = '0;
    sz    = '0;
    bad_o = 1'b0;
    for (int b = 0; b < NUM_BKT; b++) begin
      base_o[b] = acc[AW-1:0];
      sz        = ACCW'(size_i[b]);
      if (sz != '0) begin
        if (!is_pow2_or_zero(32'(size_i[b]))) bad_o = 1'b1;
        if ((acc & (sz - ACCW'(1))) != '0)     bad_o = 1'b1;
        acc = acc + sz;
      end
    end
    if (acc > ACCW'(DEPTH)) bad_o = 1'b1;
  end
endmodule

// File: rtl/msgq_store.sv
module msgq_store #(
  parameter int DEPTH = 256,
  parameter int W     = 36,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

  // R7: a read never targets the entry written in the same cycle
  a_r7_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && re_i) |-> (waddr_i != raddr_i));
endmodule

// File: rtl/msgq_bkt_ctrl.sv
module msgq_bkt_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [SW-1:0] size_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic [AW-1:0] wr_off_o,
  output logic [AW-1:0] rd_off_o,
  output logic          nonempty_o,
  output logic          ovf_o
);
  logic [SW-1:0] cnt_q;
  logic [AW-1:0] wp_q, rp_q;
  logic          full;

  assign full       = (cnt_q == size_i);
  assign wr_ok_o    = wr_i && !full && !clr_i;
  assign rd_ok_o    = rd_i && (cnt_q != '0) && !clr_i;
  assign wr_off_o   = wp_q;
  assign rd_off_o   = rp_q;
  assign nonempty_o = (cnt_q != '0);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [SW-1:0] sz);
    return ({1'b0, p} == sz - SW'(1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr_i && full) ovf_o <= 1'b1;
      if (clr_i) begin
        cnt_q <= '0;
        wp_q  <= '0;
        rp_q  <= '0;
      end else begin
        if (wr_ok_o) wp_q <= step(wp_q, size_i);
        if (rd_ok_o) rp_q <= step(rp_q, size_i);
        case ({wr_ok_o, rd_ok_o})
          2'b10:   cnt_q <= cnt_q + SW'(1);
          2'b01:   cnt_q <= cnt_q - SW'(1);
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= size_i);
  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r5_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !nonempty_o && !wr_i) |=> !nonempty_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !nonempty_o);
endmodule

// File: rtl/msgq_rx_station.sv
module msgq_rx_station
  import msgq_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int NUM_BKT = 8,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int SW     = AW + 1,
  localparam int BW     = $clog2(NUM_BKT),
  localparam int EW     = SRC_W + DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [BW-1:0]      cfg_bkt_i,
  input  logic [SW-1:0]      cfg_size_i,
  input  logic               wr_valid_i,
  input  logic [BW-1:0]      wr_bkt_i,
  input  logic [SRC_W-1:0]   wr_src_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_pop_i,
  input  logic [BW-1:0]      rd_bkt_i,
  output logic               rd_valid_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [SRC_W-1:0]   rd_src_o,
  output logic [NUM_BKT-1:0] not_empty_o,
  output logic               crd_valid_o,
  output logic [BW-1:0]      crd_bkt_o,
  output logic [SRC_W-1:0]   crd_src_o,
  output logic [NUM_BKT-1:0] overflow_o,
  output logic               cfg_error_o
);
  logic [SW-1:0]      size_q [NUM_BKT];
  logic [AW-1:0]      base   [NUM_BKT];
  logic [AW-1:0]      wr_off [NUM_BKT];
  logic [AW-1:0]      rd_off [NUM_BKT];
  logic [NUM_BKT-1:0] wr_ok, rd_ok;
  logic               layout_bad;
  logic               rd_valid_q;
  logic [BW-1:0]      rd_bkt_q;
  logic [EW-1:0]      rd_entry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BKT; b++) size_q[b] <= '0;
      cfg_error_o <= 1'b0;
      rd_valid_q  <= 1'b0;
      rd_bkt_q    <= '0;
    end else begin
      if (cfg_we_i) size_q[cfg_bkt_i] <= cfg_size_i;
      cfg_error_o <= cfg_error_o | layout_bad;
      rd_valid_q  <= rd_ok[rd_bkt_i];
      rd_bkt_q    <= rd_bkt_i;
    end
  end

  msgq_layout #(.DEPTH(DEPTH), .NUM_BKT(NUM_BKT)) u_layout (
    .size_i (size_q),
    .base_o (base),
    .bad_o  (layout_bad)
  );

  for (genvar g = 0; g < NUM_BKT; g++) begin : g_bkt
    msgq_bkt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (cfg_we_i && (cfg_bkt_i == BW'(g))),
      .size_i     (size_q[g]),
      .wr_i       (wr_valid_i && (wr_bkt_i == BW'(g))),
      .rd_i       (rd_pop_i && (rd_bkt_i == BW'(g))),
      .wr_ok_o    (wr_ok[g]),
      .rd_ok_o    (rd_ok[g]),
      .wr_off_o   (wr_off[g]),
      .rd_off_o   (rd_off[g]),
      .nonempty_o (not_empty_o[g]),
      .ovf_o      (overflow_o[g])
    );
  end

  msgq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok[wr_bkt_i]),
    .waddr_i (base[wr_bkt_i] + wr_off[wr_bkt_i]),
    .wdata_i ({wr_src_i, wr_data_i}),
    .re_i    (rd_ok[rd_bkt_i]),
    .raddr_i (base[rd_bkt_i] + rd_off[rd_bkt_i]),
    .rdata_o (rd_entry)
  );

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_entry[DATA_W-1:0];
  assign rd_src_o    = rd_entry[EW-1:DATA_W];
  assign crd_valid_o = rd_valid_q;
  assign crd_bkt_o   = rd_bkt_q;
  assign crd_src_o   = rd_entry[EW-1:DATA_W];

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_error_o |=> cfg_error_o);
  a_r5_no_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pop_i && !not_empty_o[rd_bkt_i]) |=> !crd_valid_o);
  a_r4_one_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crd_valid_o && !$past(rd_pop_i)) |-> 1'b0);
  a_r6_fill_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !cfg_we_i && !rd_pop_i && size_q[wr_bkt_i] != '0)
      |=> not_empty_o[$past(wr_bkt_i)]);
endmodule

// File: tb/msgq_rx_station_tb.sv
`timescale 1ns/1ps
module msgq_rx_station_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 0;
  logic [2:0]  cfg_bkt_i = 0;
  logic [8:0]  cfg_size_i = 0;
  logic        wr_valid_i = 0;
  logic [2:0]  wr_bkt_i = 0;
  logic [3:0]  wr_src_i = 0;
  logic [31:0] wr_data_i = 0;
  logic        rd_pop_i = 0;
  logic [2:0]  rd_bkt_i = 0;
  logic        rd_valid_o, crd_valid_o, cfg_error_o;
  logic [31:0] rd_data_o;
  logic [3:0]  rd_src_o, crd_src_o;
  logic [2:0]  crd_bkt_o;
  logic [7:0]  not_empty_o, overflow_o;

  always #2 clk_i = ~clk_i;

  msgq_rx_station u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int msz [8];
  logic [35:0] mq [8][$];
  logic [38:0] exp_q [$];
  logic [7:0]  m_ovf;
  logic        m_err;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    cfg_we_i = 0; wr_valid_i = 0; rd_pop_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    quiet(); rst_ni = 0;
    for (int b = 0; b < 8; b++) begin msz[b] = 0; mq[b].delete(); end
    exp_q.delete(); m_ovf = '0; m_err = 0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic cfg(input int b, input int sz);
    @(negedge clk_i); quiet();
    cfg_we_i = 1; cfg_bkt_i = 3'(b); cfg_size_i = 9'(sz);
    msz[b] = sz; mq[b].delete();
  endtask

  task automatic wr(input int b, input int src, input logic [31:0] d);
    @(negedge clk_i); quiet();
    wr_valid_i = 1; wr_bkt_i = 3'(b); wr_src_i = 4'(src); wr_data_i = d;
    if (mq[b].size() < msz[b]) mq[b].push_back({4'(src), d});
    else m_ovf[b] = 1'b1;
  endtask

  task automatic pop(input int b);
    @(negedge clk_i); quiet();
    rd_pop_i = 1; rd_bkt_i = 3'(b);
    if (mq[b].size() > 0) exp_q.push_back({3'(b), mq[b].pop_front()});
  endtask

  // settle and compare flags with the model (R3, R6, R8)
  task automatic settle(input string req);
    logic [7:0] ne;
    @(negedge clk_i); quiet();
    @(negedge clk_i);
    for (int b = 0; b < 8; b++) ne[b] = (mq[b].size() > 0);
    chk({req, " R6 not_empty"}, 64'(not_empty_o), 64'(ne));
    chk({req, " R3 overflow"}, 64'(overflow_o), 64'(m_ovf));
    chk({req, " R8 cfg_error"}, 64'(cfg_error_o), 64'(m_err));
  endtask

  // monitor: scoreboard compare of pops and credits (R2, R4, R5)
  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (rd_valid_o) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R5 unexpected rd_valid act=1 exp=0");
        end else begin
          logic [38:0] e;
          e = exp_q.pop_front();
          chk("R2 data", 64'(rd_data_o), 64'(e[31:0]));
          chk("R4 credit src", 64'(crd_src_o), 64'(e[35:32]));
          chk("R4 credit bkt", 64'(crd_bkt_o), 64'(e[38:36]));
          chk("R4 credit strobe", 64'(crd_valid_o), 64'd1);
        end
      end else begin
        chk("R5 R4 no credit", 64'(crd_valid_o), 64'd0);
      end
    end
  end

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 not_empty", 64'(not_empty_o), 64'd0);
    chk("R1 overflow", 64'(overflow_o), 64'd0);
    chk("R1 cfg_error", 64'(cfg_error_o), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid_o), 64'd0);
    // R3 unconfigured bucket has size 0
    wr(0, 1, 32'hdead0000);
    settle("R1 default size 0");

    // R7 tight legal layout covering all 256 entries
    do_reset();
    cfg(0, 4); cfg(1, 4); cfg(2, 8); cfg(3, 16);
    cfg(4, 32); cfg(5, 64); cfg(6, 128);
    settle("R8 legal layout");

    for (int i = 0; i < 5; i++) wr(0, i, 32'h1000 + 32'(i)); // 5th overflows R3
    for (int i = 0; i < 4; i++) wr(1, 8 + i, 32'h2000 + 32'(i));
    wr(7, 3, 32'h7777);                                        // size-0 bucket R3
    settle("R3 R7 fill");
    pop(7);                                                    // R5 empty pop
    for (int i = 0; i < 4; i++) pop(0);                        // R7 R2
    pop(0);                                                    // R5 now empty
    settle("R7 drained b0");

    // R10 wrap rounds on bucket 0 next to full bucket 1
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 3; i++) wr(0, r + i, 32'h3000 + 32'(r * 16 + i));
      for (int i = 0; i < 3; i++) pop(0);
    end
    for (int i = 0; i < 4; i++) pop(1);
    settle("R10 wrap");

    // large bucket, interleaved writes and pops across buckets R2
    for (int i = 0; i < 20; i++) begin
      wr(6, i % 16, 32'h6000 + 32'(i));
      wr(3, 15 - (i % 16), 32'h3300 + 32'(i));
      if (i % 3 == 0) pop(6);
    end
    settle("R2 interleave");

    // R9 reconfigure flushes bucket 3
    cfg(3, 16);
    settle("R9 flush");
    pop(3);
    for (int i = 0; i < 20; i++) pop(6);
    settle("R9 R5 after flush");

    // R8 misaligned start
    do_reset();
    cfg(0, 32); cfg(1, 64); m_err = 1;
    settle("R8 misaligned");
    // R8 size not a power of two
    do_reset();
    cfg(0, 48); m_err = 1;
    settle("R8 non pow2");
    // R8 total overrun
    do_reset();
    cfg(0, 128); cfg(1, 128); cfg(2, 16); m_err = 1;
    settle("R8 overrun");

    chk("R2 all pops delivered", 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule